// File: doc/BRIEF.md
# CAN Interrupt Cause and Status Register Unit

This block collects the interrupt sources of a CAN controller that manages 32 message objects and presents them to a host through a small register port. The protocol engine feeds it one-cycle event pulses: transmit success, receive success, and a last-error code. It also feeds it error-counter values and level signals for the error-passive and bus-off states. A separate 32-bit vector requests that individual message objects be marked as having an interrupt pending.

The host reads a cause register to find out why the interrupt line is high. The cause register gives a fixed status code while a status interrupt is outstanding. Otherwise it gives the number of the lowest-numbered object with a pending bit. Reading the status register acknowledges the status interrupt. Object pending bits are acknowledged through a two-register command path: a mask selects the clear action, and a request register takes the object number and stays busy for a fixed time.

Register offsets on `reg_addr` are: 0 control, 1 status, 2 cause, 3 pending low (objects 1 to 16, object n at bit n-1), 4 pending high (objects 17 to 32, object n at bit n-17), 5 command mask, 6 command request.

Top module: `can_irq_unit`

## Requirements
- R1: After a synchronous active-low reset, all of the following hold: every readable register returns 0, `irq` is low, `no_retry` is low and the command interface is not busy.
- R2: A pulse on `obj_set[k]` sets the pending bit of object k+1. Objects 1 to 16 read at bits 0 to 15 of the pending-low register. Objects 17 to 32 read at bits 0 to 15 of the pending-high register.
- R3: The cause register reads 0x8000 while a status interrupt is pending. Otherwise it reads the lowest object number (1 to 32) whose pending bit is set. It reads 0 when nothing is pending.
- R4: A read of the status register clears the pending status interrupt, unless a new status event arrives in the same cycle.
- R5: The status register bits are laid out as follows. Bit 3 is set by a transmit-ok pulse and bit 4 by a receive-ok pulse. Bits 2:0 load the error code on a code-valid pulse. The codes are 0 none, 1 stuff, 2 form, 3 acknowledge, 4 recessive-sent-dominant-seen, 5 dominant-sent-recessive-seen and 6 CRC. Bit 5 follows `err_passive` and bit 7 follows `bus_off`, each one cycle late.
- R6: Status bit 6 (error warning) is set one cycle after either error counter is at or above 96, and is clear otherwise.
- R7: A host write to the status register loads bits 4:0 from the write data. Bits 7:5 are unaffected by the write.
- R8: A status interrupt becomes pending in two cases. The first is a transmit-ok, receive-ok or nonzero error-code event while the status enable (control bit 1) is set. The second is a rising bus-off, warning or passive condition while the error enable (control bit 2) is set. No status interrupt becomes pending when the matching enable is clear.
- R9: `irq` is high only when the module enable (control bit 0) is set and the cause register is nonzero.
- R10: Control bits 3:0 are readable and writable. `no_retry` follows control bit 3.
- R11: Writing object number n to the request register while the mask's clear bit (bit 0) is set makes the request register's busy bit (bit 15) read 1 for exactly 3 cycles, after which object n's pending bit is clear. With the mask clear bit at 0, or with n outside 1 to 32, no pending bit changes.
- R12: A write to the request register while it is busy is ignored. The stored object number (bits 5:0) and the cleared object are those of the first write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid the cycle after `reg_rd` |
| obj_set | input | 32 | Per-object pending set pulses, bit k for object k+1 |
| ev_tx_ok | input | 1 | Transmit completed pulse |
| ev_rx_ok | input | 1 | Reception completed pulse |
| ev_lec_valid | input | 1 | Error code update pulse |
| ev_lec | input | 3 | Error code value |
| tx_err_cnt | input | 8 | Transmit error counter |
| rx_err_cnt | input | 8 | Receive error counter |
| err_passive | input | 1 | Error-passive level |
| bus_off | input | 1 | Bus-off level |
| irq | output | 1 | Interrupt request |
| no_retry | output | 1 | Automatic retransmission disabled |

## Verification
Every register effect lands on the clock edge of the write or pulse, so a read started on the following cycle sees it. Read data arrives one cycle after the read strobe. The error-level flags take one extra cycle, and the bench waits two cycles after changing them. The busy window is probed with four back-to-back reads of the request register issued right after the write: they must return busy, busy, busy, idle. The cleared pending bit is checked only after that. Inputs are driven and outputs sampled on the falling edge, so every check lands a fixed, counted number of edges after its stimulus.

// File: rtl/can_irq_pkg.sv
// Shared constants and types for the CAN interrupt/status unit.
// Assumes a 3-bit register offset space and 16-bit registers.
package can_irq_pkg;
    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_STAT  = 3'd1;
    localparam logic [2:0] A_CAUSE = 3'd2;
    localparam logic [2:0] A_PLO   = 3'd3;
    localparam logic [2:0] A_PHI   = 3'd4;
    localparam logic [2:0] A_CMASK = 3'd5;
    localparam logic [2:0] A_CREQ  = 3'd6;

    localparam logic [15:0] CAUSE_STATUS = 16'h8000;

    typedef enum logic [2:0] {
        LEC_NONE  = 3'd0,
        LEC_STUFF = 3'd1,
        LEC_FORM  = 3'd2,
        LEC_ACK   = 3'd3,
        LEC_BIT1  = 3'd4,
        LEC_BIT0  = 3'd5,
        LEC_CRC   = 3'd6,
        LEC_RSVD  = 3'd7
    } lec_e;

    typedef struct packed {
        logic       boff;
        logic       warn;
        logic       passive;
        logic       rx_ok;
        logic       tx_ok;
        logic [2:0] lec;
    } stat_t;

    typedef struct packed {
        logic no_retry;
        logic err_ie;
        logic stat_ie;
        logic mod_ie;
    } ctrl_t;
endpackage

// File: rtl/can_irq_status.sv
// Status register and status-interrupt pending flag.
// Holds transfer-ok flags, last error code and error-state flags; raises the
// pending flag on enabled events and drops it when the host reads status.
// Assumes event inputs are single-cycle pulses from the protocol engine.
module can_irq_status
    import can_irq_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int WARN_LIMIT = 96
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stat_ie,
    input  logic             err_ie,
    input  logic             ev_tx_ok,
    input  logic             ev_rx_ok,
    input  logic             ev_lec_valid,
    input  logic [2:0]       ev_lec,
    input  logic [CNT_W-1:0] tx_err_cnt,
    input  logic [CNT_W-1:0] rx_err_cnt,
    input  logic             err_passive,
    input  logic             bus_off,
    input  logic             host_wr,
    input  logic [4:0]       host_wdata,
    input  logic             host_rd,
    output stat_t            stat,
    output logic             stat_pend
);
    localparam logic [CNT_W-1:0] WARN_L = CNT_W'(WARN_LIMIT);

    logic warn_now;
    logic err_rise;
    logic stat_evt;
    logic err_evt;

    // Derive the warning level and the enabled interrupt triggers.
    always_comb begin
        warn_now = (tx_err_cnt >= WARN_L) || (rx_err_cnt >= WARN_L);
        err_rise = (bus_off & ~stat.boff) | (warn_now & ~stat.warn)
                 | (err_passive & ~stat.passive);
        stat_evt = stat_ie & (ev_tx_ok | ev_rx_ok
                 | (ev_lec_valid && (ev_lec != LEC_NONE)));
        err_evt  = err_ie & err_rise;
    end

    // Update status flags: host writes first, engine events take precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat <= '0;
        end else begin
            stat.boff    <= bus_off;
            stat.warn    <= warn_now;
            stat.passive <= err_passive;
            if (host_wr) begin
                stat.rx_ok <= host_wdata[4];
                stat.tx_ok <= host_wdata[3];
                stat.lec   <= host_wdata[2:0];
            end
            if (ev_tx_ok)     stat.tx_ok <= 1'b1;
            if (ev_rx_ok)     stat.rx_ok <= 1'b1;
            if (ev_lec_valid) stat.lec   <= ev_lec;
        end
    end

    // Track the status interrupt: set on events, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n)                 stat_pend <= 1'b0;
        else if (stat_evt | err_evt) stat_pend <= 1'b1;
        else if (host_rd)           stat_pend <= 1'b0;
    end

    assert_rd_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !(stat_evt || err_evt)) |=> !stat_pend);

    assert_warn_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_err_cnt >= WARN_L) |=> stat.warn);
endmodule

// File: rtl/can_irq_objpend.sv
// Per-object interrupt pending bits, clear command sequencer and priority
// encoder. A command accepted while idle stays busy for BUSY_CYC cycles and
// clears the selected object at the end. Lower object numbers win.
// Assumes object numbers are 1-based; other values clear nothing.
module can_irq_objpend #(
    parameter int NUM_OBJ  = 32,
    parameter int BUSY_CYC = 3,
    parameter int ID_W     = $clog2(NUM_OBJ + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_OBJ-1:0] obj_set,
    input  logic               clr_en,
    input  logic               req_wr,
    input  logic [ID_W-1:0]    req_num,
    output logic [NUM_OBJ-1:0] pend,
    output logic               busy,
    output logic [ID_W-1:0]    cur_num,
    output logic [ID_W-1:0]    top_id
);
    localparam int CNT_W = $clog2(BUSY_CYC + 1);

    logic [CNT_W-1:0]   cnt;
    logic               sel_q;
    logic               accept;
    logic               done;
    logic [NUM_OBJ-1:0] clr_vec;

    assign busy    = (cnt != '0);
    assign accept  = req_wr && !busy;
    assign done    = (cnt == CNT_W'(1));
    assign cur_num = num_q_w;

    logic [ID_W-1:0] num_q_w;

    // Sequence a clear command: latch request and count down the busy window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            num_q_w <= '0;
            sel_q   <= 1'b0;
        end else if (accept) begin
            cnt     <= CNT_W'(BUSY_CYC);
            num_q_w <= req_num;
            sel_q   <= clr_en;
        end else if (busy) begin
            cnt <= cnt - 1'b1;
        end
    end

    // One clear strobe per object, decoded from the latched number.
    for (genvar k = 0; k < NUM_OBJ; k++) begin : g_clr
        assign clr_vec[k] = done && sel_q && (num_q_w == ID_W'(k + 1));
    end

    // Pending bits: new set requests win over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr_vec) | obj_set;
    end

    // Priority encoder: lowest-numbered pending object, 0 when none.
    always_comb begin
        top_id = '0;
        for (int k = NUM_OBJ - 1; k >= 0; k--) begin
            if (pend[k]) top_id = ID_W'(k + 1);
        end
    end

    assert_set_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|obj_set) |=> ((pend & $past(obj_set)) == $past(obj_set)));

    assert_clear_at_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(pend) & ~pend) != '0) |-> $fell(busy));

    assert_busy_ignores_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_wr) |=> $stable(num_q_w));
endmodule

// File: rtl/can_irq_unit.sv
// Top of the CAN interrupt/status unit: register decode, control register,
// command mask, cause generation, read mux and interrupt line.
// Assumes one access per cycle and registered read data one cycle later.
module can_irq_unit
    import can_irq_pkg::*;
#(
    parameter int NUM_OBJ    = 32,
    parameter int DATA_W     = 16,
    parameter int ADDR_W     = 3,
    parameter int CNT_W      = 8,
    parameter int WARN_LIMIT = 96,
    parameter int BUSY_CYC   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [NUM_OBJ-1:0] obj_set,
    input  logic               ev_tx_ok,
    input  logic               ev_rx_ok,
    input  logic               ev_lec_valid,
    input  logic [2:0]         ev_lec,
    input  logic [CNT_W-1:0]   tx_err_cnt,
    input  logic [CNT_W-1:0]   rx_err_cnt,
    input  logic               err_passive,
    input  logic               bus_off,
    output logic               irq,
    output logic               no_retry
);
    localparam int HALF = NUM_OBJ / 2;
    localparam int ID_W = $clog2(NUM_OBJ + 1);

    ctrl_t              ctrl_q;
    logic               cmask_q;
    stat_t              stat;
    logic               stat_pend;
    logic [NUM_OBJ-1:0] pend;
    logic               busy;
    logic [ID_W-1:0]    cur_num;
    logic [ID_W-1:0]    top_id;
    logic [DATA_W-1:0]  cause;
    logic [DATA_W-1:0]  rd_mux;
    logic               unused_wdata_bits;

    assign unused_wdata_bits = ^reg_wdata[DATA_W-1:ID_W];

    wire [ADDR_W-1:0] a_ctrl  = ADDR_W'(A_CTRL);
    wire [ADDR_W-1:0] a_stat  = ADDR_W'(A_STAT);
    wire [ADDR_W-1:0] a_cause = ADDR_W'(A_CAUSE);
    wire [ADDR_W-1:0] a_plo   = ADDR_W'(A_PLO);
    wire [ADDR_W-1:0] a_phi   = ADDR_W'(A_PHI);
    wire [ADDR_W-1:0] a_cmask = ADDR_W'(A_CMASK);
    wire [ADDR_W-1:0] a_creq  = ADDR_W'(A_CREQ);

    // Control and command-mask registers written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            cmask_q <= 1'b0;
        end else if (reg_wr) begin
            if (reg_addr == a_ctrl)  ctrl_q  <= ctrl_t'(reg_wdata[3:0]);
            if (reg_addr == a_cmask) cmask_q <= reg_wdata[0];
        end
    end

    can_irq_status #(
        .CNT_W      (CNT_W),
        .WARN_LIMIT (WARN_LIMIT)
    ) u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .stat_ie      (ctrl_q.stat_ie),
        .err_ie       (ctrl_q.err_ie),
        .ev_tx_ok     (ev_tx_ok),
        .ev_rx_ok     (ev_rx_ok),
        .ev_lec_valid (ev_lec_valid),
        .ev_lec       (ev_lec),
        .tx_err_cnt   (tx_err_cnt),
        .rx_err_cnt   (rx_err_cnt),
        .err_passive  (err_passive),
        .bus_off      (bus_off),
        .host_wr      (reg_wr && (reg_addr == a_stat)),
        .host_wdata   (reg_wdata[4:0]),
        .host_rd      (reg_rd && (reg_addr == a_stat)),
        .stat         (stat),
        .stat_pend    (stat_pend)
    );

    can_irq_objpend #(
        .NUM_OBJ  (NUM_OBJ),
        .BUSY_CYC (BUSY_CYC),
        .ID_W     (ID_W)
    ) u_objpend (
        .clk     (clk),
        .rst_n   (rst_n),
        .obj_set (obj_set),
        .clr_en  (cmask_q),
        .req_wr  (reg_wr && (reg_addr == a_creq)),
        .req_num (reg_wdata[ID_W-1:0]),
        .pend    (pend),
        .busy    (busy),
        .cur_num (cur_num),
        .top_id  (top_id)
    );

    // Cause: status code overrides the object priority result.
    assign cause    = stat_pend ? DATA_W'(CAUSE_STATUS) : DATA_W'(top_id);
    assign irq      = ctrl_q.mod_ie && (cause != '0);
    assign no_retry = ctrl_q.no_retry;

    // Read multiplexer over all host-visible registers.
    always_comb begin
        rd_mux = '0;
        case (reg_addr)
            a_ctrl:  rd_mux[3:0] = ctrl_q;
            a_stat:  rd_mux[7:0] = stat;
            a_cause: rd_mux = cause;
            a_plo:   rd_mux[HALF-1:0] = pend[HALF-1:0];
            a_phi:   rd_mux[NUM_OBJ-HALF-1:0] = pend[NUM_OBJ-1:HALF];
            a_cmask: rd_mux[0] = cmask_q;
            a_creq: begin
                rd_mux[DATA_W-1] = busy;
                rd_mux[ID_W-1:0] = cur_num;
            end
            default: rd_mux = '0;
        endcase
    end

    // Register the read data for the cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end

    assert_cause_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && (reg_addr == a_cause) && stat_pend)
        |=> (reg_rdata == DATA_W'(CAUSE_STATUS)));

    assert_ctrl_retry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == a_ctrl)) |=> (no_retry == $past(reg_wdata[3])));
endmodule

// File: tb/can_irq_unit_test.sv
`timescale 1ns/1ps
module can_irq_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [31:0] obj_set = '0;
    logic        ev_tx_ok = 1'b0;
    logic        ev_rx_ok = 1'b0;
    logic        ev_lec_valid = 1'b0;
    logic [2:0]  ev_lec = '0;
    logic [7:0]  tx_err_cnt = '0;
    logic [7:0]  rx_err_cnt = '0;
    logic        err_passive = 1'b0;
    logic        bus_off = 1'b0;
    logic        irq;
    logic        no_retry;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [15:0] rv;

    always #4 clk = ~clk;

    can_irq_unit uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .obj_set(obj_set), .ev_tx_ok(ev_tx_ok), .ev_rx_ok(ev_rx_ok),
        .ev_lec_valid(ev_lec_valid), .ev_lec(ev_lec),
        .tx_err_cnt(tx_err_cnt), .rx_err_cnt(rx_err_cnt),
        .err_passive(err_passive), .bus_off(bus_off),
        .irq(irq), .no_retry(no_retry)
    );

    localparam int NV = 4;
    localparam logic [31:0] V_SET   [NV] = '{32'h8000_0000, 32'h0001_0000, 32'h0000_0020, 32'h0000_0001};
    localparam logic [15:0] V_CAUSE [NV] = '{16'd32, 16'd17, 16'd6, 16'd1};
    localparam logic [15:0] V_LO    [NV] = '{16'h0000, 16'h0000, 16'h0020, 16'h0021};
    localparam logic [15:0] V_HI    [NV] = '{16'h8000, 16'h8001, 16'h8001, 16'h8001};

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    // All tasks start and end on a falling edge.
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(8 * 20000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        rd(3'd0, rv); check("R1 ctrl", rv, 16'h0000);
        rd(3'd1, rv); check("R1 stat", rv, 16'h0000);
        rd(3'd2, rv); check("R1 cause", rv, 16'h0000);
        rd(3'd6, rv); check("R1 creq", rv, 16'h0000);
        check("R1 irq", {15'd0, irq}, 16'd0);
        check("R1 no_retry", {15'd0, no_retry}, 16'd0);

        // R10 control register
        wr(3'd0, 16'h0009);
        check("R10 no_retry set", {15'd0, no_retry}, 16'd1);
        rd(3'd0, rv); check("R10 ctrl readback", rv, 16'h0009);
        wr(3'd0, 16'h0001);
        check("R10 no_retry clear", {15'd0, no_retry}, 16'd0);

        // Vector table: R2 pending layout, R3 priority, R9 irq
        for (int i = 0; i < NV; i++) begin
            obj_set = V_SET[i];
            @(negedge clk);
            obj_set = '0;
            rd(3'd2, rv); check("R3 cause priority", rv, V_CAUSE[i]);
            rd(3'd3, rv); check("R2 pending low", rv, V_LO[i]);
            rd(3'd4, rv); check("R2 pending high", rv, V_HI[i]);
            check("R9 irq with module enable", {15'd0, irq}, 16'd1);
        end

        // R11 clear object 1, busy for exactly three cycles
        wr(3'd5, 16'h0001);
        wr(3'd6, 16'h0001);
        rd(3'd6, rv); check("R11 busy cycle 1", rv, 16'h8001);
        rd(3'd6, rv); check("R11 busy cycle 2", rv, 16'h8001);
        rd(3'd6, rv); check("R11 busy cycle 3", rv, 16'h8001);
        rd(3'd6, rv); check("R11 idle after 3", rv, 16'h0001);
        rd(3'd2, rv); check("R11 cause after clear", rv, 16'd6);
        rd(3'd3, rv); check("R11 low after clear", rv, 16'h0020);

        // R12 write while busy ignored
        wr(3'd6, 16'h0006);
        wr(3'd6, 16'h0011);
        idle(4);
        rd(3'd6, rv); check("R12 number kept", rv, 16'h0006);
        rd(3'd3, rv); check("R12 object 6 cleared", rv, 16'h0000);
        rd(3'd4, rv); check("R12 object 17 kept", rv, 16'h8001);

        // R11 mask clear, and out-of-range number: no change
        wr(3'd5, 16'h0000);
        wr(3'd6, 16'h0011);
        idle(4);
        rd(3'd4, rv); check("R11 mask off no clear", rv, 16'h8001);
        wr(3'd5, 16'h0001);
        wr(3'd6, 16'h0000);
        idle(4);
        rd(3'd2, rv); check("R11 number 0 no clear", rv, 16'd17);
        wr(3'd6, 16'h0021);
        idle(4);
        rd(3'd4, rv); check("R11 number 33 no clear", rv, 16'h8001);

        // R3/R4/R5 status interrupt with status enable
        wr(3'd0, 16'h0003);
        ev_tx_ok = 1'b1; @(negedge clk); ev_tx_ok = 1'b0;
        rd(3'd2, rv); check("R3 status code", rv, 16'h8000);
        check("R9 irq status", {15'd0, irq}, 16'd1);
        rd(3'd1, rv); check("R5 tx ok bit", rv, 16'h0008);
        rd(3'd2, rv); check("R4 read clears status", rv, 16'd17);

        ev_lec = 3'd6; ev_lec_valid = 1'b1; @(negedge clk); ev_lec_valid = 1'b0;
        rd(3'd2, rv); check("R8 error code event", rv, 16'h8000);
        rd(3'd1, rv); check("R5 crc code", rv, 16'h000E);
        ev_rx_ok = 1'b1; @(negedge clk); ev_rx_ok = 1'b0;
        rd(3'd1, rv); check("R5 rx ok bit", rv, 16'h001E);
        rd(3'd2, rv); check("R4 cleared again", rv, 16'd17);

        // R7 host write of status
        err_passive = 1'b1;
        idle(2);
        wr(3'd1, 16'h0003);
        rd(3'd1, rv); check("R7 write low bits only", rv, 16'h0023);
        err_passive = 1'b0;
        idle(2);
        rd(3'd2, rv);
        rd(3'd1, rv); check("R5 passive follows", rv, 16'h0003);
        wr(3'd1, 16'h00E0);
        rd(3'd1, rv); check("R7 upper bits ignored", rv, 16'h0000);

        // R6 warning threshold, R8 error enable gating
        tx_err_cnt = 8'd95;
        idle(2);
        rd(3'd1, rv); check("R6 below 96", rv, 16'h0000);
        rx_err_cnt = 8'd96;
        idle(2);
        rd(3'd2, rv); check("R8 error enable off", rv, 16'd17);
        rd(3'd1, rv); check("R6 at 96", rv, 16'h0040);
        wr(3'd0, 16'h0007);
        bus_off = 1'b1;
        idle(2);
        rd(3'd2, rv); check("R8 bus-off raises", rv, 16'h8000);
        rd(3'd1, rv); check("R5 bus-off bit", rv, 16'h00C0);

        // R8 status enable off: tx event does not raise
        wr(3'd0, 16'h0001);
        ev_tx_ok = 1'b1; @(negedge clk); ev_tx_ok = 1'b0;
        rd(3'd2, rv); check("R8 status enable off", rv, 16'd17);

        // R9 module enable off
        wr(3'd0, 16'h0000);
        check("R9 irq gated", {15'd0, irq}, 16'd0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule